// File: doc/BRIEF.md
# Raster Position Interrupt Timer

This block produces a programmable interrupt tied to the position of the video beam. A video timing generator supplies the current horizontal cycle count and scanline count. Software sets a horizontal compare value and a vertical compare value, each 9 bits wide and written as two bytes. It also sets three enables: one for a non-maskable pulse at the start of vertical blank, one for the scanline compare and one for the cycle compare. When the enabled compare conditions match, a sticky interrupt flag is set. The interrupt output follows that flag as a level.

The enables that are set decide which condition is used. With only the vertical enable set, the flag sets on any cycle where the scanline equals the vertical compare. With the horizontal enable set, the cycle count must equal the horizontal compare. If the vertical enable is also set, the scanline must match too, which places the interrupt at a single point on the screen. Software acknowledges the interrupt by reading a status byte. That read returns the flag and clears it. A set condition in the same cycle as the read takes priority, so no event is lost.

Top module: `raster_irq_timer`

## Requirements
- R1: After reset all three enables are 0, both compare values are 0x1FF, and `irq` and `nmi_pulse` are 0.
- R2: A write to offset 0x00 sets the NMI enable from bit 7, the vertical enable from bit 5 and the horizontal enable from bit 4. Bit 0 and every other bit have no effect.
- R3: Offset 0x07 writes horizontal compare bits 7:0 and offset 0x08 writes bit 8 from data bit 0. Offsets 0x09 and 0x0A do the same for the vertical compare. Data bits 7:1 of a high-byte write are ignored.
- R4: With only the vertical enable set, the flag sets at the clock edge of any cycle in which `v_count` equals the vertical compare.
- R5: With only the horizontal enable set, the flag sets at the clock edge of any cycle in which `h_count` equals the horizontal compare, whatever the scanline.
- R6: With both enables set, the flag sets only when `h_count` and `v_count` both equal their compare values in the same cycle.
- R7: With both the horizontal and vertical enables clear, the flag never sets.
- R8: A read of offset 0x11 returns the flag in bit 7 and `bus_page` in bits 6:0 in the same cycle. The flag clears at that clock edge. Any other cycle returns 0x00 on `rd_data`.
- R9: When a set condition and a status read fall in the same cycle, the flag stays set.
- R10: `nmi_pulse` is high for exactly the cycle after a cycle in which `vblank_start` is high, and only if the NMI enable was set in that earlier cycle.
- R11: `irq` equals the flag and stays high until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 8 | Register offset within the block |
| bus_page | input | 7 | Bus address bits 14:8, returned as open-bus bits of the status read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (status byte during a status read, else 0) |
| h_count | input | 9 | Current horizontal cycle count |
| v_count | input | 9 | Current scanline count |
| vblank_start | input | 1 | One-cycle strobe at the start of vertical blank |
| irq | output | 1 | Level interrupt request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The counters are driven at random but biased toward the compare values and their neighbours. This makes exact hits, near misses one count apart, and hits on only one axis all common. Each of these patterns is applied under every enable combination, so the vertical-only, horizontal-only, combined and disabled cases can be told apart. Status reads are placed at random, including on cycles where a match is present, which separates a clear from a set that wins over it. Directed cases cover the 0x1FF reset compare, the ignored control and high-byte bits, and a vertical-blank strobe with the NMI enable on and off.

// File: rtl/raster_irq_pkg.sv
// Shared constants and types for the raster position interrupt timer.
// Assumes an 8-bit register port decoded by offset within the block.
package raster_irq_pkg;
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_HCMP_L = 8'h07;
    localparam logic [7:0] OFF_HCMP_H = 8'h08;
    localparam logic [7:0] OFF_VCMP_L = 8'h09;
    localparam logic [7:0] OFF_VCMP_H = 8'h0A;
    localparam logic [7:0] OFF_STATUS = 8'h11;

    // Bit positions inside the control byte.
    localparam int BIT_NMI_EN = 7;
    localparam int BIT_VEN    = 5;
    localparam int BIT_HEN    = 4;

    typedef struct packed {
        logic nmi_en;
        logic v_en;
        logic h_en;
    } irq_ctrl_t;
endpackage

// File: rtl/raster_cfg_regs.sv
// Configuration storage: the enable byte and two split-written compare
// values. Assumes CNT_W > DATA_W; the high write carries CNT_W-DATA_W bits.
module raster_cfg_regs
    import raster_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output irq_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  h_cmp,
    output logic [CNT_W-1:0]  v_cmp
);
    localparam int HI_W = CNT_W - DATA_W;

    // Register updates on writes; reset puts compares at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            h_cmp <= '1;
            v_cmp <= '1;
        end else if (wr_en) begin
            case (wr_off)
                OFF_CTRL: begin
                    ctrl.nmi_en <= wr_data[BIT_NMI_EN];
                    ctrl.v_en   <= wr_data[BIT_VEN];
                    ctrl.h_en   <= wr_data[BIT_HEN];
                end
                OFF_HCMP_L: h_cmp[DATA_W-1:0]     <= wr_data;
                OFF_HCMP_H: h_cmp[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                OFF_VCMP_L: v_cmp[DATA_W-1:0]     <= wr_data;
                OFF_VCMP_H: v_cmp[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/raster_match.sv
// Combinational position compare. Chooses the condition from the enables:
// vertical only, horizontal only, or both. Assumes counters are stable
// within a cycle.
module raster_match
    import raster_irq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  irq_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] h_cmp,
    input  logic [CNT_W-1:0] v_cmp,
    input  logic [CNT_W-1:0] h_count,
    input  logic [CNT_W-1:0] v_count,
    output logic             hit
);
    logic h_eq, v_eq;

    // Equality of each axis against its compare value.
    always_comb begin
        h_eq = (h_count == h_cmp);
        v_eq = (v_count == v_cmp);
    end

    // Enable-dependent selection of the interrupt condition.
    always_comb begin
        unique case ({ctrl.h_en, ctrl.v_en})
            2'b01:   hit = v_eq;
            2'b10:   hit = h_eq;
            2'b11:   hit = h_eq && v_eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/raster_irq_flag.sv
// Sticky interrupt flag and blanking pulse. A set in the same cycle as a
// clear wins. Assumes vblank_start is a single-cycle strobe.
module raster_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic vblank_start,
    input  logic nmi_en,
    output logic flag,
    output logic nmi_pulse
);
    // Flag: set on hit, cleared by acknowledge when no hit is present.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end

    // Pulse: one registered cycle per blanking strobe when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pulse <= 1'b0;
        else        nmi_pulse <= vblank_start & nmi_en;
    end
endmodule

// File: rtl/raster_irq_timer.sv
// Top of the raster position interrupt timer. Decodes the register port,
// returns the status byte with open-bus filler and wires the sub-blocks.
// Assumes the enclosing decoder asserts reg_wr/reg_rd only for this block.
module raster_irq_timer
    import raster_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 9,
    parameter int PAGE_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_off,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  h_count,
    input  logic [CNT_W-1:0]  v_count,
    input  logic              vblank_start,
    output logic              irq,
    output logic              nmi_pulse
);
    irq_ctrl_t        ctrl;
    logic [CNT_W-1:0] h_cmp, v_cmp;
    logic             hit, flag, stat_rd, nmi_en;

    raster_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_off),
        .wr_data(wr_data), .ctrl(ctrl), .h_cmp(h_cmp), .v_cmp(v_cmp)
    );

    raster_match #(.CNT_W(CNT_W)) u_match (
        .ctrl(ctrl), .h_cmp(h_cmp), .v_cmp(v_cmp),
        .h_count(h_count), .v_count(v_count), .hit(hit)
    );

    raster_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(stat_rd),
        .vblank_start(vblank_start), .nmi_en(nmi_en),
        .flag(flag), .nmi_pulse(nmi_pulse)
    );

    // Status decode and read mux.
    always_comb begin
        stat_rd = reg_rd && (reg_off == OFF_STATUS);
        nmi_en  = ctrl.nmi_en;
        rd_data = stat_rd ? {flag, bus_page} : '0;
        irq     = flag;
    end
endmodule

// File: rtl/raster_irq_checker.sv
// Temporal checks on the raster interrupt timer, bound to its top.
module raster_irq_checker (
    input logic clk,
    input logic rst_n,
    input logic hit,
    input logic stat_rd,
    input logic irq,
    input logic nmi_pulse,
    input logic vblank_start,
    input logic nmi_en
);
    // R1: reset leaves both outputs low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !nmi_pulse));

    // R4 / R5 / R6: a compare hit raises the flag on the next cycle.
    a_r4_hit_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);

    // R7: the flag only rises after a hit.
    a_r7_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    // R8: a status read with no hit clears the flag.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !hit) |=> !irq);

    // R9: a hit during a status read keeps the flag.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && hit) |=> irq);

    // R11: without a read the flag holds.
    a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd) |=> irq);

    // R10: no pulse when disabled, and a pulse when enabled.
    a_r10_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !nmi_en) |=> !nmi_pulse);
    a_r10_nmi_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && nmi_en) |=> nmi_pulse);
endmodule

bind raster_irq_timer raster_irq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .hit(hit), .stat_rd(stat_rd), .irq(irq),
    .nmi_pulse(nmi_pulse), .vblank_start(vblank_start), .nmi_en(nmi_en)
);

// File: tb/tb_raster_irq_timer.sv
module tb_raster_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, vblank_start = 1'b0;
    logic [7:0] reg_off = '0, wr_data = '0, rd_data;
    logic [6:0] bus_page = '0;
    logic [8:0] h_count = '0, v_count = '0;
    logic       irq, nmi_pulse;

    int    n_chk = 0, n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_flag = 0, m_nmi_en = 0, m_ven = 0, m_hen = 0;
    bit [8:0] m_hcmp = 9'h1FF, m_vcmp = 9'h1FF;

    raster_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_off(reg_off), .bus_page(bus_page), .wr_data(wr_data),
        .rd_data(rd_data), .h_count(h_count), .v_count(v_count),
        .vblank_start(vblank_start), .irq(irq), .nmi_pulse(nmi_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_hit(bit hen, bit ven, bit [8:0] hc, bit [8:0] vc,
                                   bit [8:0] h, bit [8:0] v);
        if (hen) return (h == hc) && (!ven || v == vc);
        if (ven) return v == vc;
        return 0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock step, entered and left at a falling edge.
    task automatic step(bit wr, bit rd, bit [7:0] off, bit [7:0] data,
                        bit [8:0] h, bit [8:0] v, bit vb, bit [6:0] pg);
        bit st, nf, nn;
        reg_wr = wr; reg_rd = rd; reg_off = off; wr_data = data;
        h_count = h; v_count = v; vblank_start = vb; bus_page = pg;
        st = rd && off == 8'h11;
        #1;
        check({cur_req, " R8 rd_data"}, rd_data, st ? {m_flag, pg} : 8'h00);
        nf = exp_hit(m_hen, m_ven, m_hcmp, m_vcmp, h, v) | (m_flag & !st);
        nn = vb & m_nmi_en;
        if (wr) begin
            case (off)
                8'h00: begin m_nmi_en = data[7]; m_ven = data[5]; m_hen = data[4]; end
                8'h07: m_hcmp[7:0] = data;
                8'h08: m_hcmp[8]   = data[0];
                8'h09: m_vcmp[7:0] = data;
                8'h0A: m_vcmp[8]   = data[0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        m_flag = nf;
        check({cur_req, " R11 irq"}, irq, m_flag);
        check({cur_req, " R10 nmi"}, nmi_pulse, nn);
        reg_wr = 0; reg_rd = 0; vblank_start = 0;
    endtask

    task automatic wr(bit [7:0] off, bit [7:0] d);
        step(1, 0, off, d, 9'h0AA, 9'h0AA, 0, 0);
    endtask

    task automatic ack();
        step(0, 1, 8'h11, 0, 9'h0AA, 9'h0AA, 0, 7'h55);
    endtask

    function automatic bit [8:0] near(bit [8:0] c);
        case ($urandom_range(0, 4))
            0, 1:    return c;
            2:       return c + 9'd1;
            3:       return c - 9'd1;
            default: return 9'($urandom_range(0, 511));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: outputs quiet after reset
        cur_req = "R1";
        check("R1 irq", irq, 0);
        check("R1 nmi", nmi_pulse, 0);
        step(0, 0, 0, 0, 9'h1FF, 9'h1FF, 1, 0);   // R1 enables off: no nmi, no irq
        wr(8'h00, 8'h10);                         // horizontal only
        step(0, 0, 0, 0, 9'h1FF, 9'h000, 0, 0);   // R1 compare reset value 0x1FF hits
        check("R1 default hcmp hit", irq, 1);
        ack();

        // R2: bit 0 and other bits ignored
        cur_req = "R2";
        wr(8'h00, 8'h4F);
        step(0, 0, 0, 0, 9'h1FF, 9'h1FF, 1, 0);
        check("R2 no irq with bit0", irq, 0);
        wr(8'h00, 8'h80);
        step(0, 0, 0, 0, 9'h000, 9'h000, 1, 0);   // R10 nmi enabled

        // R3: high byte only uses bit 0
        cur_req = "R3";
        wr(8'h07, 8'h10); wr(8'h08, 8'hFE);
        wr(8'h09, 8'h22); wr(8'h0A, 8'h01);
        wr(8'h00, 8'h10);
        step(0, 0, 0, 0, 9'h110, 9'h000, 0, 0);
        check("R3 upper bits ignored", irq, 0);
        step(0, 0, 0, 0, 9'h010, 9'h000, 0, 0);
        check("R3 hcmp 0x010", irq, 1);
        ack();

        // R6: both axes needed
        cur_req = "R6";
        wr(8'h00, 8'h30);
        step(0, 0, 0, 0, 9'h010, 9'h000, 0, 0);
        check("R6 h only no irq", irq, 0);
        step(0, 0, 0, 0, 9'h010, 9'h122, 0, 0);
        check("R6 both irq", irq, 1);

        // R9: hit during read keeps flag
        cur_req = "R9";
        step(0, 1, 8'h11, 0, 9'h010, 9'h122, 0, 7'h3C);
        check("R9 set wins", irq, 1);
        ack();
        check("R8 cleared", irq, 0);

        // R4 / R5 / R7 random mix
        cur_req = "R4 R5 R7 random";
        for (int i = 0; i < 4000; i++) begin
            int k = $urandom_range(0, 19);
            if (k == 0)
                wr(8'h00, 8'($urandom_range(0, 255)));
            else if (k == 1)
                wr(8'($urandom_range(0, 1) ? 8'h07 : 8'h09), 8'($urandom_range(0, 255)));
            else if (k == 2)
                wr(8'($urandom_range(0, 1) ? 8'h08 : 8'h0A), 8'($urandom_range(0, 255)));
            else
                step(0, $urandom_range(0, 3) == 0, 8'h11, 0,
                     near(m_hcmp), near(m_vcmp), $urandom_range(0, 7) == 0,
                     7'($urandom_range(0, 127)));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule